// File: doc/BRIEF.md
# Edge and Gate Pulse Accumulator with Timer Clock Selection

This block is the pulse-accumulation part of a timer peripheral. It holds a 16-bit count that advances in one of two ways. In event mode it advances on each chosen edge of an external pin. In gated mode it advances once per divide-by-64 tick of the timer time base, but only while the pin is at a chosen level. The pin passes through a synchronizer before any edge or level is used. The block sets two flags: one when the count wraps and one on pin activity. Software can clear these flags by writing ones to them. In fast-clear mode, any access to the count clears them instead.

The block also chooses the clock enable for the main timer counter. It can pass on the timer prescaler tick. It can also supply the accumulator's own advance pulse, that pulse divided by 256, or that pulse divided by 65536. Each choice is a single-cycle enable pulse in the one system clock domain. The choice takes effect in the cycle after the control write, with no wait for a counter boundary.

The register port is a plain single-cycle select/write port, not a stream. A read returns data combinationally in the cycle it is selected, and a write takes effect at the next clock edge. The port has no back-pressure. There is no flowing data interface, so no valid/ready handshake is used.

Top module: `pacc_top`

## Requirements
- R1: After reset, the control register (address 0), the flag register (address 1) and the count register (address 2) all read zero, and address 3 always reads zero.
- R2: In event mode (control bit 2 = 0, bit 0 = 1), the count advances by exactly one for each falling edge of the synchronized pin when control bit 1 = 0, and for each rising edge when bit 1 = 1. Opposite edges do not advance it.
- R3: In gated mode (control bit 2 = 1, bit 0 = 1), the count advances once per GATE_DIV-cycle tick while the synchronized pin is high (bit 1 = 0) or low (bit 1 = 1). If the pin stays at the active level for exactly k*GATE_DIV cycles, the count advances by exactly k. It does not advance while the pin is at the other level.
- R4: The count never advances while the accumulator enable (control bit 0) is 0. In gated mode it never advances while the timer enable input is 0.
- R5: The overflow flag (flag register bit 1) sets when the count advances from all ones to zero, and stays clear before that.
- R6: The input flag (flag register bit 0) sets on each selected edge in event mode. In gated mode it sets when the pin leaves its active level.
- R7: Flag register bits 15 to 2 read zero. When fast clear (control bit 5) is 0, writing 1 to a flag bit clears that flag and writing 0 leaves it. When fast clear is 1, writes to the flag register have no effect.
- R8: When fast clear is 1 and the timer enable is 1, any read or write of the count register clears both flags. When the timer enable is 0, such an access leaves the flags unchanged.
- R9: With the accumulator enabled, the timer clock select (control bits 4:3) drives tcnt_tick from one of four sources: 0 selects pre_tick, 1 selects the accumulator advance pulse, 2 selects that pulse divided by MID_DIV, and 3 selects that pulse divided by MID_DIV*HI_STAGE. A selection takes effect in the cycle after the control write.
- R10: While the accumulator enable is 0, tcnt_tick follows pre_tick whatever the clock select field holds.
- R11: A write to the count register loads the written value. If an advance falls in the same cycle, the write takes priority over it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable; runs the gate time base and permits fast clear |
| pre_tick | input | 1 | Timer prescaler clock-enable pulse |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe (with reg_cs) |
| reg_addr | input | 2 | Register address: 0 control, 1 flags, 2 count |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, valid in the selected cycle |
| tcnt_tick | output | 1 | Clock enable for the main timer counter |

## Verification
The bench builds the block with a 16-bit count, GATE_DIV = 4, MID_DIV = 4 and HI_STAGE = 4. These small settings let a gate window of a few cycles give an exact expected count. They also bring both divided timer-clock sources within reach of 8 and 16 pin pulses. The count stays at 16 bits, and the bench reaches the wrap by loading a value just below all ones. The bench sweeps all four pin actions, all four clock selects with the accumulator both on and off, and both flag-clear modes with the timer enable both on and off.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic [1:0] {
    CS_PRESCALE = 2'd0,
    CS_ACC      = 2'd1,
    CS_MID      = 2'd2,
    CS_HI       = 2'd3
  } clk_sel_e;

  typedef struct packed {
    logic     fast_clr;
    clk_sel_e clk_sel;
    logic     gated;
    logic     level_sel;
    logic     acc_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_FLAGS = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;

endpackage

// File: rtl/pacc_div_stage.sv
module pacc_div_stage #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = step && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/pacc_pin_sync.sv
module pacc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= pin_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[i] <= 1'b0;
      else        sh_q[i] <= sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = level_o && !prev_q;
  assign fall_o  = !level_o && prev_q;

  // R2
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GATE_DIV    = 64,
  parameter int MID_DIV     = 256,
  parameter int HI_STAGE    = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic             pre_tick,
  input  logic             pin_i,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             tcnt_tick
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t            ctrl_q;
  logic             ovf_q, inf_q;
  logic [CNT_W-1:0] count_q;

  logic lvl, rise, fall;
  logic gate_tick, mid_tick, hi_tick;
  logic gate_active, edge_hit, inc;
  logic ctrl_wr, flg_wr, cnt_acc, cnt_wr;
  logic fast_hit, w1c_ovf, w1c_inf, wrap, in_set;

  pacc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pacc_div_stage #(.DIV(GATE_DIV)) u_gate_div (
    .clk(clk), .rst_n(rst_n), .clr(!tmr_en), .step(tmr_en), .tick(gate_tick)
  );

  pacc_div_stage #(.DIV(MID_DIV)) u_mid_div (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .step(inc), .tick(mid_tick)
  );

  pacc_div_stage #(.DIV(HI_STAGE)) u_hi_div (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .step(mid_tick), .tick(hi_tick)
  );

  // access decode
  assign ctrl_wr = reg_cs && reg_we && (reg_addr == A_CTRL);
  assign flg_wr  = reg_cs && reg_we && (reg_addr == A_FLAGS);
  assign cnt_acc = reg_cs && (reg_addr == A_COUNT);
  assign cnt_wr  = cnt_acc && reg_we;

  // pin action
  assign gate_active = ctrl_q.level_sel ? !lvl : lvl;
  assign edge_hit    = ctrl_q.level_sel ? rise : fall;
  assign inc = ctrl_q.acc_en &&
               (ctrl_q.gated ? (gate_tick && gate_active) : edge_hit);

  // flag events
  assign wrap     = inc && (count_q == CNT_MAX) && !cnt_wr;
  assign in_set   = ctrl_q.acc_en && edge_hit;
  assign fast_hit = ctrl_q.fast_clr && tmr_en && cnt_acc;
  assign w1c_ovf  = flg_wr && !ctrl_q.fast_clr && reg_wdata[1];
  assign w1c_inf  = flg_wr && !ctrl_q.fast_clr && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_wr) count_q <= reg_wdata;
    else if (inc)    count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      inf_q <= 1'b0;
    end else begin
      if (wrap)                     ovf_q <= 1'b1;
      else if (fast_hit || w1c_ovf) ovf_q <= 1'b0;
      if (in_set)                   inf_q <= 1'b1;
      else if (fast_hit || w1c_inf) inf_q <= 1'b0;
    end
  end

  // timer counter clock selection
  always_comb begin
    if (!ctrl_q.acc_en) tcnt_tick = pre_tick;
    else begin
      unique case (ctrl_q.clk_sel)
        CS_PRESCALE: tcnt_tick = pre_tick;
        CS_ACC:      tcnt_tick = inc;
        CS_MID:      tcnt_tick = mid_tick;
        CS_HI:       tcnt_tick = hi_tick;
        default:     tcnt_tick = pre_tick;
      endcase
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_cs) begin
      unique case (reg_addr)
        A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
        A_FLAGS: reg_rdata[1:0]        = {ovf_q, inf_q};
        A_COUNT: reg_rdata             = count_q;
        default: reg_rdata             = '0;
      endcase
    end
  end

  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(reg_wdata)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> ((count_q == $past(count_q)) ||
                 (count_q == $past(count_q) + 1'b1)));

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.gated && !tmr_en && !cnt_wr) |=> (count_q == $past(count_q)));

  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (count_q == CNT_MAX) && !cnt_wr) |=> (ovf_q && (count_q == '0)));

  // R8
  fast_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_hit && !inc && !in_set) |=> (!ovf_q && !inf_q));

  // R10
  no_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.acc_en |-> (tcnt_tick == pre_tick));

  // R7
  flag_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cs && (reg_addr == A_FLAGS)) |-> (reg_rdata[CNT_W-1:2] == '0));

endmodule

// File: tb/pacc_top_bench.sv
module pacc_top_bench;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 16;
  localparam int GDIV   = 4;
  localparam int MDIV   = 4;
  localparam int HSTG   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0;
  logic pre_tick = 1'b0;
  logic pin_i = 1'b0;
  logic reg_cs = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic tcnt_tick;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  int pre_cnt = 0;
  int pre_ph = 0;
  bit done = 0;

  pacc_top #(.CNT_W(CNT_W), .SYNC_STAGES(2), .GATE_DIV(GDIV),
             .MID_DIV(MDIV), .HI_STAGE(HSTG)) u_pacc_top (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .pre_tick(pre_tick),
    .pin_i(pin_i), .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tcnt_tick(tcnt_tick)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    pre_ph <= (pre_ph + 1) % 3;
    pre_tick <= (pre_ph == 0);
  end

  always @(negedge clk) begin
    if (tcnt_tick) tick_cnt <= tick_cnt + 1;
    if (pre_tick)  pre_cnt  <= pre_cnt + 1;
  end

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); #1;
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = CNT_W'(d);
    @(posedge clk); #1;
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk); #1;
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = int'(reg_rdata);
    @(posedge clk); #1;
    reg_cs = 1'b0;
  endtask

  function automatic int cw(input int acc, input int lvl, input int gated,
                            input int sel, input int fast);
    return (fast << 5) | (sel << 3) | (gated << 2) | (lvl << 1) | acc;
  endfunction

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      step(1); pin_i = 1'b1; step(3); pin_i = 1'b0; step(2);
    end
    step(4);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, t0, p0;
    step(4);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 flags", v, 0);
    rd(2'd2, v); check("R1 count", v, 0);
    rd(2'd3, v); check("R1 addr3", v, 0);

    // R2 / R6 event mode sweep over both edges and pulse counts
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(2'd0, cw(1, lvl, 0, 1, 0));
        wr(2'd2, 0);
        wr(2'd1, 3);
        pulses(n);
        rd(2'd2, v); check("R2 edge count", v, n);
        rd(2'd1, v); check("R6 edge flag", v & 1, 1);
      end
    end

    // R4 accumulator disabled
    wr(2'd0, cw(0, 1, 0, 1, 0));
    wr(2'd2, 7);
    pulses(3);
    rd(2'd2, v); check("R4 acc off", v, 7);

    // R3 / R6 gated mode sweep
    tmr_en = 1'b1;
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int k = 1; k <= 4; k++) begin
        pin_i = (lvl == 1);
        step(4);
        wr(2'd0, cw(1, lvl, 1, 1, 0));
        wr(2'd2, 0);
        wr(2'd1, 3);
        step(20);
        rd(2'd2, v); check("R3 gate idle", v, 0);
        rd(2'd1, v); check("R6 gate idle flag", v, 0);
        step(1); pin_i = (lvl == 0);
        step(k * GDIV);
        pin_i = (lvl == 1);
        step(6);
        rd(2'd2, v); check("R3 gate count", v, k);
        rd(2'd1, v); check("R6 trailing flag", v & 1, 1);
      end
    end
    pin_i = 1'b0;

    // R4 gated with timer disabled
    tmr_en = 1'b0;
    wr(2'd2, 0);
    step(1); pin_i = 1'b1; step(24); pin_i = 1'b0; step(6);
    rd(2'd2, v); check("R4 gate timer off", v, 0);
    tmr_en = 1'b1;

    // R5 overflow
    wr(2'd0, cw(1, 1, 0, 1, 0));
    wr(2'd2, 16'hFFFE);
    wr(2'd1, 3);
    pulses(1);
    rd(2'd1, v); check("R5 no wrap yet", v, 1);
    pulses(1);
    rd(2'd2, v); check("R5 wrapped count", v, 0);
    rd(2'd1, v); check("R5 ovf flag", v, 3);

    // R7 write-one-to-clear
    wr(2'd1, 0);
    rd(2'd1, v); check("R7 write zero keeps", v, 3);
    wr(2'd1, 1);
    rd(2'd1, v); check("R7 clear input flag", v, 2);
    wr(2'd1, 16'hFFFE);
    rd(2'd1, v); check("R7 clear ovf, upper zero", v, 0);

    // R7 / R8 fast clear
    wr(2'd2, 16'hFFFF);
    pulses(1);
    wr(2'd0, cw(1, 1, 0, 1, 1));
    wr(2'd1, 3);
    rd(2'd1, v); check("R7 flag write ignored", v, 3);
    tmr_en = 1'b0;
    rd(2'd2, v);
    rd(2'd1, v); check("R8 no clear timer off", v, 3);
    tmr_en = 1'b1;
    rd(2'd2, v);
    rd(2'd1, v); check("R8 clear on read", v, 0);
    wr(2'd0, cw(1, 1, 0, 1, 0));
    wr(2'd2, 16'hFFFF);
    pulses(1);
    wr(2'd0, cw(1, 1, 0, 1, 1));
    wr(2'd2, 5);
    rd(2'd1, v); check("R8 clear on write", v, 0);
    rd(2'd2, v); check("R11 count load", v, 5);

    // R9 / R10 timer clock selection sweep
    for (int acc = 0; acc < 2; acc++) begin
      for (int sel = 0; sel < 4; sel++) begin
        int np, exp_t;
        wr(2'd0, cw(acc, 1, 0, sel, 0));
        np = (sel == 3) ? 16 : 8;
        step(1);
        t0 = tick_cnt; p0 = pre_cnt;
        pulses(np);
        if (acc == 0 || sel == 0) exp_t = pre_cnt - p0;
        else if (sel == 1) exp_t = np;
        else if (sel == 2) exp_t = np / MDIV;
        else exp_t = np / (MDIV * HSTG);
        if (acc == 0) check("R10 follows prescale", tick_cnt - t0, exp_t);
        else          check("R9 clock select", tick_cnt - t0, exp_t);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule